// File: doc/BRIEF.md
# Phase-Accumulator Variable Frequency Generator

This block is a numerically controlled oscillator. A 16-bit control word sets a phase increment. Every reference clock cycle, the block adds that increment into a 16-bit phase accumulator. The accumulator's most significant bit is driven out as a square wave. A single-cycle tick is also produced on each rising edge of that wave. A downstream fixed-frequency pulse-width stage can use the tick as a clock enable.

The control word arrives as two byte-wide writes over one shared data bus.

- A write of the upper half parks the byte in a staging register. It has no other effect.
- A write of the lower half commits the full word, made of the staged upper half and the new lower half.

Before accumulation, the committed word is decoded into an effective increment. Words below half scale are used as they are. Words at or above half scale are replaced by their two's complement within the word width. The output frequency is the effective increment divided by 2^16, times the reference clock frequency.

When the output clocks a pulse-width stage, the control word should be kept between 1 and 32768. Power-of-two words in that range give an exact 50% duty square wave.

Top module: `nco_varfreq_gen`

## Requirements
- R1: After reset the accumulator is zero, the committed word and the staged byte are zero, and both `wave_out` and `tick_out` are low.
- R2: A write with only `wr_hi` high changes neither the committed word nor the outputs. The byte is only staged.
- R3: A write with `wr_lo` high commits the word {staged upper byte, `wr_data`}. The first accumulation using the new word happens on the clock edge after the one that samples the write.
- R4: The effective increment equals the committed word when bit 15 of the word is 0. Otherwise it is (65536 - word) modulo 65536, so 0xFFFA and 0x0006 run at the same rate.
- R5: Each cycle the accumulator advances by the effective increment modulo 2^16, and `wave_out` is accumulator bit 15. Over N cycles starting from zero, the number of ticks equals the count of values 32768 + 65536*j that are not above N*W.
- R6: `tick_out` is high for exactly one cycle, in the first cycle that `wave_out` is high after being low. It is never high while `wave_out` is low.
- R7: For a power-of-two word 2^k with 4 <= k <= 15, `wave_out` is high for exactly half of any window that spans whole periods of 2^(16-k) cycles.
- R8: A committed word of zero freezes the accumulator, so `wave_out` holds its level and no tick occurs.
- R9: When `wr_hi` and `wr_lo` are both high in one cycle, the committed word is {`wr_data`, `wr_data`}. The upper half comes from this cycle's byte, not from the old staged one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Stage `wr_data` as the upper half of the control word |
| wr_lo | input | 1 | Commit the control word, taking `wr_data` as the lower half |
| wr_data | input | 8 | Byte written by `wr_hi` or `wr_lo` |
| wave_out | output | 1 | Square wave, accumulator MSB |
| tick_out | output | 1 | One-cycle strobe on each rising edge of `wave_out` |

## Verification
Two pairs of functions can fall in the same clock cycle.

- A commit and an accumulation step share a cycle. The bench drives a low-byte write and checks that the edge sampling it still adds the old increment, and that the new increment shows one edge later (R3).
- An upper-byte stage and a commit can land together. The bench raises both strobes in one cycle and judges the result from the tick count over a 32768-cycle window, which must match the word {byte, byte} (R9).

Every cycle is also compared against an arithmetic model of the accumulator kept in the bench.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int unsigned NCO_CW_W = 16;

  // Effective phase step: the word itself below half scale,
  // its two's complement (within w bits) at or above half scale.
  function automatic logic [31:0] eff_inc(input logic [31:0] cw, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    if (cw[w-1]) return (~cw + 32'd1) & mask;
    else return cw & mask;
  endfunction

endpackage

// File: rtl/nco_cword_loader.sv
module nco_cword_loader #(
  parameter int CW_W = nco_pkg::NCO_CW_W,
  localparam int HALF_W = CW_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  output logic [CW_W-1:0]   cword
);

  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] upper_src;

  // A same-cycle upper write feeds the commit directly.
  assign upper_src = wr_hi ? wr_data : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      cword   <= '0;
    end else begin
      if (wr_hi) stage_q <= wr_data;
      if (wr_lo) cword   <= {upper_src, wr_data};
    end
  end

  AST_HI_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(cword)); // R2

  AST_NO_COMMIT_WITHOUT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(cword)); // R3

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int CW_W = nco_pkg::NCO_CW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] cword,
  output logic [CW_W-1:0] inc,
  output logic            wave
);

  logic [CW_W-1:0] acc_q;

  assign inc  = CW_W'(nco_pkg::eff_inc(32'(cword), CW_W));
  assign wave = acc_q[CW_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + inc;
  end

  AST_ZERO_WORD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (cword == '0) |=> $stable(acc_q)); // R8

  AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    inc <= (CW_W'(1) << (CW_W - 1))); // R4

endmodule

// File: rtl/nco_edge_tick.sv
module nco_edge_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic tick
);

  logic level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign tick = level & ~level_d;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6

endmodule

// File: rtl/nco_varfreq_gen.sv
module nco_varfreq_gen #(
  parameter int CW_W = nco_pkg::NCO_CW_W,
  localparam int HALF_W = CW_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wr_data,
  output logic              wave_out,
  output logic              tick_out
);

  logic [CW_W-1:0] cword;
  logic [CW_W-1:0] inc;

  nco_cword_loader #(.CW_W(CW_W)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .cword   (cword)
  );

  nco_phase_acc #(.CW_W(CW_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .cword (cword),
    .inc   (inc),
    .wave  (wave_out)
  );

  nco_edge_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .level (wave_out),
    .tick  (tick_out)
  );

  AST_TICK_NEEDS_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> wave_out); // R6

  AST_ZERO_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) |=> !tick_out); // R8

endmodule

// File: tb/tb_nco_varfreq_gen.sv
module tb_nco_varfreq_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wave_out;
  logic       tick_out;

  int n_tests = 0;
  int n_fail  = 0;
  int mism    = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  nco_varfreq_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .wave_out(wave_out), .tick_out(tick_out)
  );

  // Arithmetic reference model
  int unsigned m_acc = 0, m_cw = 0, m_stage = 0;
  bit m_prev = 0;

  function automatic int unsigned rate_of(input int unsigned w);
    return (w < 32768) ? w : (65536 - w) % 65536;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_acc <= 0; m_cw <= 0; m_stage <= 0; m_prev <= 0;
    end else begin
      m_prev <= m_acc[15];
      m_acc  <= (m_acc + rate_of(m_cw)) % 65536;
      if (wr_hi) m_stage <= wr_data;
      if (wr_lo) m_cw <= ((wr_hi ? int'(wr_data) : m_stage) << 8) | wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (wave_out !== m_acc[15] || tick_out !== (m_acc[15] & ~m_prev)) mism++;
  endtask

  task automatic wr(input bit hi, input bit lo, input logic [7:0] d);
    wr_hi = hi; wr_lo = lo; wr_data = d;
    step();
    wr_hi = 0; wr_lo = 0; wr_data = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic load(input int unsigned w);
    wr(1, 0, w[15:8]);
    wr(0, 1, w[7:0]);
  endtask

  function automatic longint exp_ticks(input longint n, input longint w);
    longint s = n * w;
    return (s >= 32768) ? (s - 32768) / 65536 + 1 : 0;
  endfunction

  task automatic count_ticks(input int n, output int t);
    t = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (tick_out) t++;
    end
  endtask

  initial begin : watchdog
    wait (cycles >= 195000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<195000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int t;
    int hi_cnt;
    bit frozen;
    bit lvl;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(wave_out === 0 && tick_out === 0, "R1 outputs after reset", {wave_out, tick_out}, 0);
    count_ticks(50, t);
    chk(t == 0 && wave_out === 0, "R1 idle word zero", t, 0);

    // R2 upper byte alone only stages
    wr(1, 0, 8'h80);
    count_ticks(100, t);
    chk(t == 0 && wave_out === 0, "R2 staged byte no effect", t, 0);

    // R3 commit timing: word 0x8000 takes effect one edge after the write
    wr_lo = 1; wr_data = 8'h00;
    step();
    wr_lo = 0;
    chk(wave_out === 0, "R3 no step on commit edge", wave_out, 0);
    step();
    chk(wave_out === 1 && tick_out === 1, "R3 first step after commit", {wave_out, tick_out}, 3);
    step();
    chk(wave_out === 0 && tick_out === 0, "R7 half-scale toggles", {wave_out, tick_out}, 0);

    // R8 zero word freezes
    load(0);
    lvl = wave_out;
    frozen = 1;
    t = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (wave_out !== lvl) frozen = 0;
      if (tick_out) t++;
    end
    chk(frozen && t == 0, "R8 zero word holds", t, 0);

    // R5 tick rate from reset
    do_reset(); load(16'h0006);
    count_ticks(32768, t);
    chk(t == exp_ticks(32768, 6), "R5 ticks for word 6", t, exp_ticks(32768, 6));

    // R4 upper half words use two's complement
    do_reset(); load(16'hFFFA);
    count_ticks(32768, t);
    chk(t == exp_ticks(32768, 6), "R4 word 0xFFFA runs as 6", t, exp_ticks(32768, 6));

    // R9 simultaneous upper and lower write
    do_reset(); wr(1, 0, 8'h11);
    wr(1, 1, 8'h40);
    count_ticks(32768, t);
    chk(t == exp_ticks(32768, 16'h4040), "R9 both strobes word", t, exp_ticks(32768, 16'h4040));

    // R7 power-of-two sweep, 50% duty over two periods
    for (int k = 4; k <= 15; k++) begin
      int p;
      p = 1 << (16 - k);
      do_reset(); load(1 << k);
      hi_cnt = 0;
      for (int i = 0; i < 2 * p; i++) begin
        step();
        if (wave_out) hi_cnt++;
      end
      chk(hi_cnt == p, $sformatf("R7 duty for 2^%0d", k), hi_cnt, p);
    end

    // R4 near half-scale words
    do_reset(); load(16'h8001);
    count_ticks(4096, t);
    chk(t == exp_ticks(4096, 32767), "R4 word 0x8001", t, exp_ticks(4096, 32767));

    // R5 R6 cycle-by-cycle comparison against the model over the whole run
    chk(mism == 0, "R5 R6 per-cycle model match", mism, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule